// File: doc/BRIEF.md
# Down-Spread Triangle Offset Generator

This block computes a signed frequency-offset word for a synthesizable test-clock model. A downstream period generator turns this word into a clock period. The word combines two terms. The first is a fixed offset, signed and in 0.1 ppm units, that models a reference mismatch between the two link partners. The second is a triangular spread-spectrum term that only ever lowers the frequency. The spread term starts at zero, ramps down to the full programmed deviation, and ramps back up to zero. Each of the four quarters of the triangle is a linear ramp with a programmable number of steps, and a prescaler sets how many reference cycles each step lasts.

A small state machine walks the four quarters of the triangle. Its states are `ST_IDLE`, `ST_FALL_A`, `ST_FALL_B`, `ST_RISE_A` and `ST_RISE_B`, and it reports the current quarter on a 2-bit quadrant output. The transitions are:

- `ST_IDLE` goes to `ST_FALL_A` when enable is high.
- Each active state moves to the next quarter after its step count is used up: `ST_FALL_A` to `ST_FALL_B`, `ST_FALL_B` to `ST_RISE_A`, `ST_RISE_A` to `ST_RISE_B`, and `ST_RISE_B` back to `ST_FALL_A`.
- Any active state returns to `ST_IDLE` when enable is low.

A depth counter climbs during the two falling quarters and descends during the two rising ones. The spread term is the deviation scaled by depth over twice the steps per quarter. The sum of the two terms is clamped to ±`OUT_LIM` and registered.

Top module: `ssc_downspread_gen`

## Requirements
- R1: While reset is asserted, `offset_out` is 0 and `quadrant` is 0.
- R2: With `en` low, `quadrant` reads 0 after the next clock edge. From the second edge on, `offset_out` equals the clamped static offset.
- R3: While enabled, the depth advances by one step every `step_div` reference cycles (0 is treated as 1). Depth starts from 0 at the first edge at which `en` is seen high.
- R4: The depth rises from 0 to 2×Q over 2×Q steps, then falls back to 0 over 2×Q steps, and repeats with a period of 4×Q steps. Q is `steps_cfg`, with 0 treated as 1.
- R5: `quadrant` encodes the quarter of the triangle: 0 for the first falling quarter, 1 for the second falling quarter, 2 for the first rising quarter and 3 for the second rising quarter. It changes only every Q steps, and only to the next value modulo 4.
- R6: The spread term is −floor(`dev_cfg` × depth ÷ (2×Q)). It is never positive, and it equals exactly −`dev_cfg` at the peak depth 2×Q.
- R7: `offset_out` equals `static_off` plus the spread term, clamped to the range −`OUT_LIM`..+`OUT_LIM`. It is registered, so it reflects the depth held one cycle earlier.
- R8: Dropping `en` in the middle of a sweep discards the position. The next enable restarts at depth 0 in quadrant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables the triangular sweep |
| dev_cfg | input | DEV_W | Spread deviation magnitude, 0.1 ppm units |
| steps_cfg | input | STEP_W | Steps per quarter of the triangle (0 treated as 1) |
| step_div | input | DIV_W | Reference cycles per step (0 treated as 1) |
| static_off | input | OFS_W | Signed static offset, 0.1 ppm units |
| offset_out | output | OUT_W | Signed total offset, 0.1 ppm units |
| quadrant | output | 2 | Current quarter of the triangle |

## Verification
Take the first edge at which `en` is sampled high as edge 0. At the sample after edge n, the quadrant is due at once: it is the quarter of step floor(n/`step_div`). The offset lags by one register, so it is compared against the depth computed for edge n−1. On disable, the bench expects the quadrant to clear after one edge and the offset to equal the static value after two edges. Every sample is taken on the falling clock edge, against those counted positions.

// File: rtl/ssc_gen_pkg.sv
package ssc_gen_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FALL_A,
        ST_FALL_B,
        ST_RISE_A,
        ST_RISE_B
    } sweep_state_t;
endpackage

// File: rtl/ssc_step_prescaler.sv
module ssc_step_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             step_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff   = (div_cfg == '0) ? DIV_W'(1) : div_cfg;
    assign step_tick = run && (cnt == div_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || step_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/ssc_sweep_fsm.sv
module ssc_sweep_fsm
    import ssc_gen_pkg::*;
#(
    parameter int STEP_W = 10,
    localparam int DEP_W = STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step_tick,
    input  logic [STEP_W-1:0] q_eff,
    output logic              run,
    output logic [DEP_W-1:0]  depth,
    output logic [1:0]        quadrant
);
    sweep_state_t      state, nxt;
    logic [STEP_W-1:0] qcnt;
    logic              quarter_end;
    logic              falling;

    assign quarter_end = step_tick && (qcnt == q_eff - STEP_W'(1));
    assign falling     = (state == ST_FALL_A) || (state == ST_FALL_B);
    assign run         = en && (state != ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (en) nxt = ST_FALL_A;
            ST_FALL_A: if (!en) nxt = ST_IDLE; else if (quarter_end) nxt = ST_FALL_B;
            ST_FALL_B: if (!en) nxt = ST_IDLE; else if (quarter_end) nxt = ST_RISE_A;
            ST_RISE_A: if (!en) nxt = ST_IDLE; else if (quarter_end) nxt = ST_RISE_B;
            ST_RISE_B: if (!en) nxt = ST_IDLE; else if (quarter_end) nxt = ST_FALL_A;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qcnt  <= '0;
            depth <= '0;
        end else if (!run) begin
            qcnt  <= '0;
            depth <= '0;
        end else if (step_tick) begin
            qcnt  <= quarter_end ? '0 : qcnt + STEP_W'(1);
            depth <= falling ? depth + DEP_W'(1) : depth - DEP_W'(1);
        end
    end

    always_comb begin
        unique case (state)
            ST_FALL_B: quadrant = 2'd1;
            ST_RISE_A: quadrant = 2'd2;
            ST_RISE_B: quadrant = 2'd3;
            default:   quadrant = 2'd0;
        endcase
    end
endmodule

// File: rtl/ssc_offset_calc.sv
module ssc_offset_calc #(
    parameter int DEV_W   = 16,
    parameter int STEP_W  = 10,
    parameter int OFS_W   = 16,
    parameter int OUT_W   = 18,
    parameter int OUT_LIM = 60000,
    localparam int DEP_W  = STEP_W + 1,
    localparam int PROD_W = DEV_W + DEP_W,
    localparam int SUM_W  = PROD_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEV_W-1:0]        dev_cfg,
    input  logic [STEP_W-1:0]       q_eff,
    input  logic [DEP_W-1:0]        depth,
    input  logic signed [OFS_W-1:0] static_off,
    output logic signed [OUT_W-1:0] offset_out
);
    localparam logic signed [SUM_W-1:0] HI_LIM = SUM_W'(OUT_LIM);
    localparam logic signed [SUM_W-1:0] LO_LIM = -SUM_W'(OUT_LIM);

    logic [PROD_W-1:0]        prod;
    logic [PROD_W-1:0]        mag;
    logic [DEP_W-1:0]         den;
    logic signed [SUM_W-1:0]  stat_x;
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  clipped;

    assign den    = {q_eff, 1'b0};
    assign prod   = PROD_W'(dev_cfg) * PROD_W'(depth);
    assign mag    = prod / PROD_W'(den);
    assign stat_x = SUM_W'(static_off);
    assign sum    = stat_x - $signed({2'b00, mag});

    always_comb begin
        if (sum > HI_LIM) begin
            clipped = HI_LIM;
        end else if (sum < LO_LIM) begin
            clipped = LO_LIM;
        end else begin
            clipped = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_out <= '0;
        end else begin
            offset_out <= OUT_W'(clipped);
        end
    end
endmodule

// File: rtl/ssc_downspread_gen.sv
module ssc_downspread_gen #(
    parameter int DEV_W   = 16,
    parameter int STEP_W  = 10,
    parameter int DIV_W   = 16,
    parameter int OFS_W   = 16,
    parameter int OUT_W   = 18,
    parameter int OUT_LIM = 60000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [DEV_W-1:0]        dev_cfg,
    input  logic [STEP_W-1:0]       steps_cfg,
    input  logic [DIV_W-1:0]        step_div,
    input  logic signed [OFS_W-1:0] static_off,
    output logic signed [OUT_W-1:0] offset_out,
    output logic [1:0]              quadrant
);
    localparam int DEP_W = STEP_W + 1;

    logic              run;
    logic              step_tick;
    logic [DEP_W-1:0]  depth;
    logic [STEP_W-1:0] q_eff;

    assign q_eff = (steps_cfg == '0) ? STEP_W'(1) : steps_cfg;

    ssc_step_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div_cfg   (step_div),
        .step_tick (step_tick)
    );

    ssc_sweep_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .step_tick (step_tick),
        .q_eff     (q_eff),
        .run       (run),
        .depth     (depth),
        .quadrant  (quadrant)
    );

    ssc_offset_calc #(
        .DEV_W   (DEV_W),
        .STEP_W  (STEP_W),
        .OFS_W   (OFS_W),
        .OUT_W   (OUT_W),
        .OUT_LIM (OUT_LIM)
    ) u_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_cfg    (dev_cfg),
        .q_eff      (q_eff),
        .depth      (depth),
        .static_off (static_off),
        .offset_out (offset_out)
    );
endmodule

// File: rtl/ssc_downspread_gen_chk.sv
module ssc_downspread_gen_chk #(
    parameter int OFS_W   = 16,
    parameter int OUT_W   = 18,
    parameter int OUT_LIM = 60000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic signed [OFS_W-1:0] static_off,
    input logic signed [OUT_W-1:0] offset_out,
    input logic [1:0]              quadrant
);
    localparam logic signed [OUT_W:0] HI = (OUT_W+1)'(OUT_LIM);
    localparam logic signed [OUT_W:0] LO = -((OUT_W+1)'(OUT_LIM));

    logic past_valid;
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // R2
    idle_quadrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> quadrant == 2'd0);

    // R2
    idle_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !en && !$past(en) |=> offset_out == OUT_W'($past(static_off)));

    // R5
    quadrant_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && quadrant != $past(quadrant) |->
            (quadrant == $past(quadrant) + 2'd1) || (quadrant == 2'd0));

    // R6
    down_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> offset_out <= OUT_W'($past(static_off)));

    // R7
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((OUT_W+1)'(offset_out) <= HI) && ((OUT_W+1)'(offset_out) >= LO));
endmodule

bind ssc_downspread_gen ssc_downspread_gen_chk #(
    .OFS_W   (OFS_W),
    .OUT_W   (OUT_W),
    .OUT_LIM (OUT_LIM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .static_off (static_off),
    .offset_out (offset_out),
    .quadrant   (quadrant)
);

// File: tb/ssc_downspread_gen_test.sv
`timescale 1ns/1ps
module ssc_downspread_gen_test;
    localparam int LIM = 60000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               en;
    logic [15:0]        dev_cfg;
    logic [9:0]         steps_cfg;
    logic [15:0]        step_div;
    logic signed [15:0] static_off;
    logic signed [17:0] offset_out;
    logic [1:0]         quadrant;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ssc_downspread_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .dev_cfg(dev_cfg),
        .steps_cfg(steps_cfg), .step_div(step_div), .static_off(static_off),
        .offset_out(offset_out), .quadrant(quadrant)
    );

    function automatic longint sat(longint v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    // R3 R4: depth after edge n counted from the first enabled edge
    function automatic longint depth_at(int q, int dv, int n);
        longint qe = (q == 0) ? 1 : q;
        longint de = (dv == 0) ? 1 : dv;
        longint p;
        if (n < 0) return 0;
        p = (longint'(n) / de) % (4 * qe);
        return (p <= 2 * qe) ? p : 4 * qe - p;
    endfunction

    // R5
    function automatic longint quad_at(int q, int dv, int n);
        longint qe = (q == 0) ? 1 : q;
        longint de = (dv == 0) ? 1 : dv;
        return ((longint'(n) / de) % (4 * qe)) / qe;
    endfunction

    // R6 R7
    function automatic longint off_for(int dev, int q, int st, longint d);
        longint qe = (q == 0) ? 1 : q;
        return sat(longint'(st) - (longint'(dev) * d) / (2 * qe));
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(int dev, int q, int dv, int st, int ncyc);
        longint qe = (q == 0) ? 1 : q;
        @(negedge clk);
        dev_cfg = 16'(dev); steps_cfg = 10'(q); step_div = 16'(dv);
        static_off = 16'(st); en = 1'b1;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (n == 0) check("R8 restart quadrant", longint'(quadrant), 0);
            check("R4/R5 quadrant", longint'(quadrant), quad_at(q, dv, n));
            check("R3/R7 offset", longint'(offset_out),
                  off_for(dev, q, st, depth_at(q, dv, n - 1)));
            if (depth_at(q, dv, n - 1) == 2 * qe)
                check("R6 peak", longint'(offset_out), sat(longint'(st) - dev));
        end
        en = 1'b0;
        @(negedge clk);
        check("R2 quadrant idle", longint'(quadrant), 0);
        @(negedge clk);
        check("R2 offset idle", longint'(offset_out), sat(st));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; en = 1'b0; dev_cfg = '0; steps_cfg = 10'd4;
        step_div = 16'd1; static_off = 16'sd1234;
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset offset", longint'(offset_out), 0);
        check("R1 reset quadrant", longint'(quadrant), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2: static only while disabled, then a change of the static value
        check("R2 static only", longint'(offset_out), 1234);
        static_off = -16'sd7000;
        repeat (2) @(negedge clk);
        check("R2 static change", longint'(offset_out), -7000);

        // directed corners
        run_case(50000, 5, 1, 0, 45);         // R6 exact peak
        run_case(40000, 0, 0, 6000, 12);      // R3 R4 zero treated as one
        run_case(65535, 3, 2, -20000, 30);    // R7 negative clamp
        run_case(30000, 4, 3, 7000, 23);      // R8 mid-sweep stop
        run_case(50000, 1000, 1, -6000, 4100);// R4 full-length period

        for (int i = 0; i < 25; i++) begin
            run_case(int'($urandom % 65536), int'($urandom % 12) + 1,
                     int'($urandom % 5) + 1, int'($urandom % 14001) - 7000,
                     int'($urandom % 280) + 20);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule